// File: doc/BRIEF.md
# Integer Multiply/Divide Unit

This unit sits next to a processor pipeline and performs 32-bit integer multiplication and division on its own. Results go into a 64-bit register pair, with a high half and a low half. The pipeline issues an operation with two 32-bit operands, a first operand `rs` and a second operand `rt`. It can then continue with unrelated work and read the pair only when it needs the result. The `busy` output tells the pipeline that a result is still pending and that new issues are not being taken.

Multiplication time depends on the size of the second operand. When `rt` is small enough to be a 16-bit value, the product is ready after one clock, and a new multiply can be issued on every cycle. Any other multiply takes a second clock, during which `busy` is high. Multiply-accumulate and multiply-subtract fold the product into the pair's current contents.

Division is iterative. It skips the leading bits of the dividend that carry no information, 8 bits at a time, so a small dividend finishes sooner. Software can load either half of the pair directly, and such a load cancels any operation that is still running.

Top module: `mdu_core`

## Requirements
- R1: After reset, `busy` is low and both `hi_out` and `lo_out` read zero.
- R2: `issue_op` selects the operation: 0 signed multiply, 1 unsigned multiply, 2 signed multiply-add, 3 unsigned multiply-add, 4 signed multiply-subtract, 5 unsigned multiply-subtract, 6 signed divide, 7 unsigned divide. Bit 0 set means unsigned. A plain multiply places the full 64-bit product of `rs` and `rt` in {`hi_out`,`lo_out`}.
- R3: Multiply-add replaces {`hi_out`,`lo_out`} with its old value plus the 64-bit product. Multiply-subtract replaces it with the old value minus the product. Both wrap modulo 2^64.
- R4: `rt` counts as narrow when bits 31..15 are all equal (signed ops) or bits 31..16 are zero (unsigned ops). A narrow multiply's result is visible after the issuing clock edge, `busy` stays low, and one such multiply is accepted on every cycle.
- R5: A multiply whose `rt` is not narrow raises `busy` for exactly one cycle. Its result is visible after the second clock edge, counting the issuing edge as the first.
- R6: A divide puts the quotient, truncated toward zero, in `lo_out` and the remainder in `hi_out`. For signed divide the remainder has the sign of the dividend. The quotient of the most negative value divided by -1 wraps to 0x80000000.
- R7: Take the dividend's magnitude: its absolute value for signed divide, its value for unsigned divide. If that magnitude fits in 8, 16, 24 or 32 bits, the result appears at the 11th, 19th, 27th or 33rd clock edge, counting the issuing edge as the first. `busy` stays high from the issue until that edge.
- R8: A divide by zero completes with the latency of R7 and raises no fault. The values it leaves in the register pair are unspecified.
- R9: An issue is taken only on a cycle where `busy` is low. A request held through a busy period is taken on the first cycle `busy` is low, and not earlier.
- R10: While `busy` is high, `hi_out` and `lo_out` keep the values they had before the operation was issued.
- R11: `hi_wr_en` loads `hi_wr_data` into the high half at the next edge, and `lo_wr_en` loads `lo_wr_data` into the low half in the same way. Either write cancels a running operation, so `busy` is low after that edge and the unwritten half is unchanged. An issue in the same cycle as a write is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_valid | input | 1 | Operation request |
| issue_op | input | 3 | Operation code (see R2) |
| issue_rs | input | 32 | First operand; dividend for divide |
| issue_rt | input | 32 | Second operand; divisor for divide |
| busy | output | 1 | Result pending; issues are not accepted |
| hi_out | output | 32 | High half of the result pair |
| lo_out | output | 32 | Low half of the result pair |
| hi_wr_en | input | 1 | Load the high half |
| hi_wr_data | input | 32 | Value for the high half |
| lo_wr_en | input | 1 | Load the low half |
| lo_wr_data | input | 32 | Value for the low half |

## Verification
The assertions assume that the caller keeps `issue_op`, `issue_rs` and `issue_rt` steady in the cycle an issue is taken. They also assume that direct loads of the pair come only from software moves, never in the same cycle as a completing operation unless the load is meant to win. The stimulus drives every input half a cycle away from the sampling edge. It issues only after seeing `busy` low, except in the deliberate stall and same-cycle-load cases. It keeps a model of the register pair that follows each load, so that R10 and R11 can be checked against the value the pair ought to keep.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

    localparam int XLEN        = 32;
    localparam int HALF        = XLEN / 2;
    localparam int DIV_STEP    = 8;
    localparam int DIV_CLASSES = XLEN / DIV_STEP;
    localparam int DIV_PAD     = 2;
    localparam int CLS_W       = $clog2(DIV_CLASSES);
    localparam int CNT_W       = $clog2(XLEN + DIV_PAD + 2);
    localparam int MUL_AW      = XLEN + 1;
    localparam int MUL_BW      = HALF + 2;
    localparam int MUL_PW      = MUL_AW + MUL_BW;
    localparam int PAIR_W      = 2 * XLEN;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_MUL_HI = 2'd1,
        ST_DIV    = 2'd2
    } mdu_state_e;

    typedef struct packed {
        mdu_state_e           state;
        logic [XLEN-1:0]      hi;
        logic [XLEN-1:0]      lo;
        logic [2:0]           op;
        logic [XLEN-1:0]      rs;
        logic [HALF-1:0]      rt_hi;
        logic [PAIR_W-1:0]    part;
    } core_t;

    typedef struct packed {
        logic                 active;
        logic [CNT_W-1:0]     cnt;
        logic [CNT_W-1:0]     iter;
        logic [XLEN-1:0]      dvd;
        logic [XLEN-1:0]      rem;
        logic [XLEN-1:0]      quo;
        logic [XLEN-1:0]      dvs;
        logic                 neg_q;
        logic                 neg_r;
    } div_t;

    // bit 0 of the operation code set means unsigned
    function automatic logic op_signed(input logic [2:0] op);
        return ~op[0];
    endfunction

    function automatic logic op_is_div(input logic [2:0] op);
        return op[2] & op[1];
    endfunction

endpackage

// File: rtl/mdu_opwidth.sv
module mdu_opwidth
    import mdu_pkg::*;
(
    input  logic                 sgn,
    input  logic [XLEN-1:0]      rs,
    input  logic [XLEN-1:HALF-1] rt_top,
    output logic                 narrow,
    output logic [CLS_W-1:0]     div_cls
);

    logic [XLEN-1:0] mag;

    always_comb begin
        if (sgn) begin
            narrow = (rt_top == '0) || (rt_top == '1);
        end else begin
            narrow = (rt_top[XLEN-1:HALF] == '0);
        end

        mag = (sgn && rs[XLEN-1]) ? (~rs + 1'b1) : rs;

        div_cls = CLS_W'(DIV_CLASSES - 1);
        for (int k = DIV_CLASSES - 2; k >= 0; k--) begin
            if ((mag >> (DIV_STEP * (k + 1))) == '0) begin
                div_cls = CLS_W'(k);
            end
        end
    end

endmodule

// File: rtl/mdu_mult.sv
module mdu_mult #(
    parameter int AW = 33,
    parameter int BW = 18
) (
    input  logic signed [AW-1:0]    a,
    input  logic signed [BW-1:0]    b,
    output logic signed [AW+BW-1:0] p
);

    assign p = a * b;

endmodule

// File: rtl/mdu_div.sv
module mdu_div
    import mdu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic              sgn,
    input  logic [XLEN-1:0]   dvd,
    input  logic [XLEN-1:0]   dvs,
    input  logic [CLS_W-1:0]  cls,
    output logic              done,
    output logic [XLEN-1:0]   quo,
    output logic [XLEN-1:0]   rem
);

    div_t dv_d, dv_q;

    int              bits;
    int              lat;
    logic [XLEN-1:0] dvd_mag;
    logic [XLEN-1:0] dvs_mag;
    logic [XLEN:0]   trial;
    logic            fits;
    logic [XLEN-1:0] s_rem;
    logic [XLEN-1:0] s_quo;

    always_comb begin
        dv_d = dv_q;

        bits    = DIV_STEP * (int'(cls) + 1);
        lat     = bits + 1 + ((bits == XLEN) ? 0 : DIV_PAD);
        dvd_mag = (sgn && dvd[XLEN-1]) ? (~dvd + 1'b1) : dvd;
        dvs_mag = (sgn && dvs[XLEN-1]) ? (~dvs + 1'b1) : dvs;

        trial = {dv_q.rem, dv_q.dvd[XLEN-1]};
        fits  = (trial >= {1'b0, dv_q.dvs});
        if (dv_q.iter != '0) begin
            s_rem = fits ? XLEN'(trial - {1'b0, dv_q.dvs}) : trial[XLEN-1:0];
            s_quo = {dv_q.quo[XLEN-2:0], fits};
        end else begin
            s_rem = dv_q.rem;
            s_quo = dv_q.quo;
        end

        done = dv_q.active && (dv_q.cnt == CNT_W'(1));
        quo  = dv_q.neg_q ? (~s_quo + 1'b1) : s_quo;
        rem  = dv_q.neg_r ? (~s_rem + 1'b1) : s_rem;

        if (dv_q.active) begin
            dv_d.cnt = dv_q.cnt - 1'b1;
            dv_d.rem = s_rem;
            dv_d.quo = s_quo;
            if (dv_q.iter != '0) begin
                dv_d.iter = dv_q.iter - 1'b1;
                dv_d.dvd  = dv_q.dvd << 1;
            end
            if (done) begin
                dv_d.active = 1'b0;
            end
        end

        if (start) begin
            dv_d.active = 1'b1;
            dv_d.cnt    = CNT_W'(lat - 1);
            dv_d.iter   = CNT_W'(bits);
            dv_d.dvd    = dvd_mag << (XLEN - bits);
            dv_d.rem    = '0;
            dv_d.quo    = '0;
            dv_d.dvs    = dvs_mag;
            dv_d.neg_q  = sgn & (dvd[XLEN-1] ^ dvs[XLEN-1]);
            dv_d.neg_r  = sgn & dvd[XLEN-1];
        end

        if (abort) begin
            dv_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dv_q <= '0;
        end else begin
            dv_q <= dv_d;
        end
    end

endmodule

// File: rtl/mdu_core.sv
module mdu_core
    import mdu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_valid,
    input  logic [2:0]       issue_op,
    input  logic [XLEN-1:0]  issue_rs,
    input  logic [XLEN-1:0]  issue_rt,
    output logic             busy,
    output logic [XLEN-1:0]  hi_out,
    output logic [XLEN-1:0]  lo_out,
    input  logic             hi_wr_en,
    input  logic [XLEN-1:0]  hi_wr_data,
    input  logic             lo_wr_en,
    input  logic [XLEN-1:0]  lo_wr_data
);

    core_t st_d, st_q;

    logic                     narrow;
    logic [CLS_W-1:0]         div_cls;
    logic                     div_start;
    logic                     div_done;
    logic [XLEN-1:0]          div_quo;
    logic [XLEN-1:0]          div_rem;
    logic                     wr_any;
    logic                     accept;
    logic                     m_sgn;
    logic [2:0]               m_op;
    logic signed [MUL_AW-1:0] m_a;
    logic signed [MUL_BW-1:0] m_b;
    logic signed [MUL_PW-1:0] m_p;
    logic [PAIR_W-1:0]        prod;
    logic [PAIR_W-1:0]        full;
    logic [PAIR_W-1:0]        acc;
    logic [PAIR_W-1:0]        result;

    mdu_opwidth u_width (
        .sgn     (op_signed(issue_op)),
        .rs      (issue_rs),
        .rt_top  (issue_rt[XLEN-1:HALF-1]),
        .narrow  (narrow),
        .div_cls (div_cls)
    );

    mdu_mult #(
        .AW (MUL_AW),
        .BW (MUL_BW)
    ) u_mult (
        .a (m_a),
        .b (m_b),
        .p (m_p)
    );

    mdu_div u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .abort (wr_any),
        .sgn   (op_signed(issue_op)),
        .dvd   (issue_rs),
        .dvs   (issue_rt),
        .cls   (div_cls),
        .done  (div_done),
        .quo   (div_quo),
        .rem   (div_rem)
    );

    always_comb begin
        wr_any    = hi_wr_en | lo_wr_en;
        accept    = issue_valid && (st_q.state == ST_IDLE);
        div_start = accept && op_is_div(issue_op) && !wr_any;

        // operand selection for the shared 33x18 multiplier
        if (st_q.state == ST_MUL_HI) begin
            m_op  = st_q.op;
            m_sgn = op_signed(st_q.op);
            m_a   = {m_sgn & st_q.rs[XLEN-1], st_q.rs};
            m_b   = {(m_sgn ? {2{st_q.rt_hi[HALF-1]}} : 2'b00), st_q.rt_hi};
        end else begin
            m_op  = issue_op;
            m_sgn = op_signed(issue_op);
            m_a   = {m_sgn & issue_rs[XLEN-1], issue_rs};
            m_b   = narrow ? issue_rt[MUL_BW-1:0] : {2'b00, issue_rt[HALF-1:0]};
        end

        prod = {{(PAIR_W - MUL_PW){m_p[MUL_PW-1]}}, m_p};
        full = (st_q.state == ST_MUL_HI) ? (st_q.part + (prod << HALF)) : prod;
        acc  = {st_q.hi, st_q.lo};
        case (m_op[2:1])
            2'b01:   result = acc + full;
            2'b10:   result = acc - full;
            default: result = full;
        endcase

        st_d = st_q;
        case (st_q.state)
            ST_IDLE: begin
                if (accept) begin
                    if (op_is_div(issue_op)) begin
                        st_d.state = ST_DIV;
                    end else if (narrow) begin
                        {st_d.hi, st_d.lo} = result;
                    end else begin
                        st_d.state = ST_MUL_HI;
                        st_d.op    = issue_op;
                        st_d.rs    = issue_rs;
                        st_d.rt_hi = issue_rt[XLEN-1:HALF];
                        st_d.part  = prod;
                    end
                end
            end
            ST_MUL_HI: begin
                {st_d.hi, st_d.lo} = result;
                st_d.state         = ST_IDLE;
            end
            ST_DIV: begin
                if (div_done) begin
                    st_d.hi    = div_rem;
                    st_d.lo    = div_quo;
                    st_d.state = ST_IDLE;
                end
            end
            default: st_d.state = ST_IDLE;
        endcase

        // a direct load wins over everything else and cancels work
        if (wr_any) begin
            st_d       = st_q;
            st_d.state = ST_IDLE;
            if (hi_wr_en) begin
                st_d.hi = hi_wr_data;
            end
            if (lo_wr_en) begin
                st_d.lo = lo_wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy   = (st_q.state != ST_IDLE);
    assign hi_out = st_q.hi;
    assign lo_out = st_q.lo;

endmodule

// File: rtl/mdu_core_chk.sv
module mdu_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        issue_valid,
    input logic [2:0]  issue_op,
    input logic [31:0] issue_rt,
    input logic        busy,
    input logic [31:0] hi_out,
    input logic [31:0] lo_out,
    input logic        hi_wr_en,
    input logic [31:0] hi_wr_data,
    input logic        lo_wr_en,
    input logic [31:0] lo_wr_data
);

    logic       take;
    logic       is_mul;
    logic       rt_small;
    logic [7:0] run_q;

    assign take     = issue_valid && !busy && !hi_wr_en && !lo_wr_en;
    assign is_mul   = !(issue_op[2] && issue_op[1]);
    assign rt_small = issue_op[0] ? (issue_rt[31:16] == 16'h0)
                                  : ((issue_rt[31:15] == 17'h0) || (issue_rt[31:15] == 17'h1ffff));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (busy) begin
            run_q <= (run_q == 8'hff) ? run_q : run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    // R4
    narrow_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && is_mul && rt_small) |=> !busy);

    // R5
    wide_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && is_mul && !rt_small) |=> busy);

    // R7
    div_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !is_mul) |=> busy);

    // R7
    busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= 8'd32);

    // R10
    hilo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(hi_out) && $stable(lo_out)));

    // R11
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_wr_en || lo_wr_en) |=> !busy);

    // R11
    hi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_wr_en |=> (hi_out == $past(hi_wr_data)));

    // R11
    lo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lo_wr_en |=> (lo_out == $past(lo_wr_data)));

endmodule

bind mdu_core mdu_core_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .issue_op    (issue_op),
    .issue_rt    (issue_rt),
    .busy        (busy),
    .hi_out      (hi_out),
    .lo_out      (lo_out),
    .hi_wr_en    (hi_wr_en),
    .hi_wr_data  (hi_wr_data),
    .lo_wr_en    (lo_wr_en),
    .lo_wr_data  (lo_wr_data)
);

// File: tb/mdu_core_bench.sv
`timescale 1ns/1ps
module mdu_core_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        issue_valid;
    logic [2:0]  issue_op;
    logic [31:0] issue_rs;
    logic [31:0] issue_rt;
    logic        busy;
    logic [31:0] hi_out;
    logic [31:0] lo_out;
    logic        hi_wr_en;
    logic [31:0] hi_wr_data;
    logic        lo_wr_en;
    logic [31:0] lo_wr_data;

    int          checks = 0;
    int          fails  = 0;
    bit          done   = 1'b0;
    logic [63:0] model;

    always #2.5 clk = ~clk;

    mdu_core u_mdu_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_valid (issue_valid),
        .issue_op    (issue_op),
        .issue_rs    (issue_rs),
        .issue_rt    (issue_rt),
        .busy        (busy),
        .hi_out      (hi_out),
        .lo_out      (lo_out),
        .hi_wr_en    (hi_wr_en),
        .hi_wr_data  (hi_wr_data),
        .lo_wr_en    (lo_wr_en),
        .lo_wr_data  (lo_wr_data)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] op_ref(input logic [2:0] op, input logic [31:0] a,
                                           input logic [31:0] b, input logic [63:0] acc);
        logic signed [63:0] sa, sb;
        logic [63:0]        ua, ub, p, q, r;
        sa = {{32{a[31]}}, a};
        sb = {{32{b[31]}}, b};
        ua = {32'h0, a};
        ub = {32'h0, b};
        p  = op[0] ? (ua * ub) : 64'(sa * sb);
        case (op[2:1])
            2'b00: return p;
            2'b01: return acc + p;
            2'b10: return acc - p;
            default: begin
                if (op[0]) begin
                    q = ua / ub;
                    r = ua % ub;
                end else begin
                    q = 64'(sa / sb);
                    r = 64'(sa % sb);
                end
                return {r[31:0], q[31:0]};
            end
        endcase
    endfunction

    function automatic int lat_ref(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] mag;
        if (op[2] && op[1]) begin
            mag = (!op[0] && a[31]) ? (~a + 1) : a;
            if (mag < 32'h100)     return 11;
            if (mag < 32'h10000)   return 19;
            if (mag < 32'h1000000) return 27;
            return 33;
        end
        if (op[0]) return (b < 32'h10000) ? 1 : 2;
        return (($signed(b) >= -32768) && ($signed(b) <= 32767)) ? 1 : 2;
    endfunction

    task automatic run_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        int          lat;
        int          exp_lat;
        logic [63:0] exp_val;
        bit          is_div;
        bit          zero_div;
        string       vtag;
        string       ltag;
        while (busy) @(negedge clk);
        is_div   = op[2] && op[1];
        zero_div = is_div && (b == 32'h0);
        exp_lat  = lat_ref(op, a, b);
        exp_val  = op_ref(op, a, b, model);
        vtag     = is_div ? "R6" : ((op[2:1] == 2'b00) ? "R2" : "R3");
        ltag     = zero_div ? "R8" : (is_div ? "R7" : ((exp_lat == 1) ? "R4" : "R5"));
        issue_valid = 1'b1;
        issue_op    = op;
        issue_rs    = a;
        issue_rt    = b;
        @(negedge clk);
        issue_valid = 1'b0;
        lat = 1;
        while (busy && lat < 60) begin
            // R10: pair held while the operation is pending
            chk("R10", {hi_out, lo_out}, model);
            @(negedge clk);
            lat++;
        end
        chk(ltag, 64'(lat), 64'(exp_lat));
        if (zero_div) begin
            model = {hi_out, lo_out};
        end else begin
            chk(vtag, {hi_out, lo_out}, exp_val);
            model = exp_val;
        end
    endtask

    logic [31:0] vals [20] = '{
        32'h00000000, 32'h00000001, 32'h00000002, 32'h00000007,
        32'h00000064, 32'hffffff9c, 32'h00007fff, 32'h00008000,
        32'hffff8000, 32'hffff7fff, 32'h0000ffff, 32'h00010000,
        32'h00ffffff, 32'h12345678, 32'h7fffffff, 32'h80000000,
        32'hffffffff, 32'hdeadbeef, 32'h000000ff, 32'h00000100
    };

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n       = 1'b0;
        issue_valid = 1'b0;
        issue_op    = 3'd0;
        issue_rs    = '0;
        issue_rt    = '0;
        hi_wr_en    = 1'b0;
        hi_wr_data  = '0;
        lo_wr_en    = 1'b0;
        lo_wr_data  = '0;
        model       = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", {63'h0, busy}, 64'h0);
        chk("R1", {hi_out, lo_out}, 64'h0);

        // R2 R3 R4 R5 R6 R7 R8: sweep every operation over the operand set
        for (int op = 0; op < 8; op++) begin
            for (int i = 0; i < 20; i++) begin
                for (int j = 0; j < 20; j++) begin
                    run_op(3'(op), vals[i], vals[j]);
                end
            end
        end

        // R4: narrow multiply-adds on consecutive cycles
        for (int k = 0; k < 4; k++) begin
            issue_valid = 1'b1;
            issue_op    = 3'd2;
            issue_rs    = 32'(1000 + k);
            issue_rt    = -32'(k + 3);
            model       = op_ref(3'd2, issue_rs, issue_rt, model);
            @(negedge clk);
            chk("R4", {63'h0, busy}, 64'h0);
        end
        issue_valid = 1'b0;
        chk("R4", {hi_out, lo_out}, model);

        // R9: a request held through a divide is taken only afterwards
        issue_valid = 1'b1;
        issue_op    = 3'd6;
        issue_rs    = 32'h7fffffff;
        issue_rt    = 32'd3;
        @(negedge clk);
        issue_op = 3'd0;
        issue_rs = 32'd5;
        issue_rt = 32'd6;
        while (busy) @(negedge clk);
        chk("R9", {hi_out, lo_out}, {32'd1, 32'h2aaaaaaa});
        @(negedge clk);
        issue_valid = 1'b0;
        chk("R9", {hi_out, lo_out}, 64'd30);
        model = 64'd30;

        // R11: a load of the high half cancels a running divide
        issue_valid = 1'b1;
        issue_op    = 3'd7;
        issue_rs    = 32'hffffffff;
        issue_rt    = 32'd7;
        @(negedge clk);
        issue_valid = 1'b0;
        repeat (2) @(negedge clk);
        hi_wr_en   = 1'b1;
        hi_wr_data = 32'ha5a5a5a5;
        @(negedge clk);
        hi_wr_en = 1'b0;
        chk("R11", {63'h0, busy}, 64'h0);
        chk("R11", {hi_out, lo_out}, {32'ha5a5a5a5, model[31:0]});
        repeat (40) @(negedge clk);
        chk("R11", {hi_out, lo_out}, {32'ha5a5a5a5, model[31:0]});
        model = {hi_out, lo_out};

        // R11: an issue in the same cycle as a load of the low half is dropped
        issue_valid = 1'b1;
        issue_op    = 3'd1;
        issue_rs    = 32'd3;
        issue_rt    = 32'd3;
        lo_wr_en    = 1'b1;
        lo_wr_data  = 32'h00000011;
        @(negedge clk);
        issue_valid = 1'b0;
        lo_wr_en    = 1'b0;
        chk("R11", {hi_out, lo_out}, {model[63:32], 32'h00000011});
        @(negedge clk);
        chk("R11", {63'h0, busy}, 64'h0);
        chk("R11", {hi_out, lo_out}, {model[63:32], 32'h00000011});

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule